// File: doc/BRIEF.md
# Dual-Issue Program Flow Sequencer

This block steers instruction fetch for a vector microprocessor that issues one 64-bit instruction pair per clock. It holds the program counter and steps it by one pair per issued cycle. It carries out taken branches after a single delay-slot pair, and a branch taken inside that delay slot is chained to the next target. A decoder outside the block supplies the branch decision and the branch target. The flag bits in the upper word of each pair control stopping. An end flag lets one trailing pair run and then stops the machine. A debug-break flag or a trap flag stops it at once and pulses an interrupt, but only when the matching enable input is high. The immediate flag captures the lower word into an immediate register.

An idle sequencer starts when the start strobe arrives with an entry address. The running status output drops when the machine stops. If a branch is still waiting for its delay slot at that point, the block issues one more pair with running already low, then applies the branch and goes idle. The debug and trap status bits hold their value until the next start.

Top module: `vseq_top`

## Requirements
- R1: After reset, and at once while reset is held low (even in mid-run), pc_o is 0, running_o, issue_o, irq_o, dbg_stat_o and trap_stat_o are 0, and imm_o is 0.
- R2: A start strobe while idle loads pc_o with start_pc_i with its three low bits cleared and raises running_o at the next edge. A start strobe while pairs are still issuing has no effect.
- R3: Each issued pair with no branch due advances pc_o by 8, wrapping modulo 2^PC_W.
- R4: When br_taken_i is high on an issued pair, the next pair (the delay slot) is at pc+8. After the delay slot, pc_o becomes br_target_i.
- R5: A branch taken inside a delay slot is queued. The pair at the first target issues, and then pc_o becomes the second target.
- R6: An end flag (upper bit 30) on an issued pair lets exactly one more pair issue. After that pair, running_o and issue_o are 0 and pc_o holds its value.
- R7: A debug-break flag (upper bit 28) on a running pair with dbg_en_i high ends issue after that pair, sets dbg_stat_o and pulses irq_o for one cycle. With dbg_en_i low, the flag has no effect.
- R8: A trap flag (upper bit 27) on a running pair with trap_en_i high ends issue after that pair, sets trap_stat_o and pulses irq_o for one cycle. With trap_en_i low, the flag has no effect.
- R9: An issued pair with the immediate flag (upper bit 31) loads lower_i into imm_o. Any pair without that flag leaves imm_o unchanged.
- R10: If a stop occurs while a branch is pending, one tail pair issues with running_o already 0. pc_o then becomes the branch target and issue ends.
- R11: dbg_stat_o and trap_stat_o hold their value while idle and are cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe |
| start_pc_i | input | PC_W | Entry byte address |
| dbg_en_i | input | 1 | Enable for the debug-break flag |
| trap_en_i | input | 1 | Enable for the trap flag |
| upper_i | input | 32 | Upper word of the pair at pc_o |
| lower_i | input | 32 | Lower word of the pair at pc_o |
| br_taken_i | input | 1 | Decoder reports a taken branch in this pair |
| br_target_i | input | PC_W | Branch target byte address |
| pc_o | output | PC_W | Program counter (byte address of the current pair) |
| issue_o | output | 1 | The pair at pc_o issues this cycle |
| running_o | output | 1 | Running status bit |
| dbg_stat_o | output | 1 | Debug-break stop status |
| trap_stat_o | output | 1 | Trap stop status |
| irq_o | output | 1 | One-cycle interrupt pulse |
| imm_o | output | 32 | Immediate register |

## Verification
Every result is registered. The effect of a pair on pc_o, the status bits, irq_o and imm_o therefore appears one rising edge after that pair's inputs are presented. The one exception is the delayed effects (delay slot, end trailing pair, tail pair), which land one further pair later, each at its own edge. The bench changes inputs on the falling edge and compares outputs on the next falling edge, so each table row covers exactly one rising edge. The delayed effects are checked through consecutive rows. The response to reset is sampled a moment after reset is asserted, because it is asynchronous.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  localparam int FLAG_IMM_BIT  = 31;
  localparam int FLAG_END_BIT  = 30;
  localparam int FLAG_DBG_BIT  = 28;
  localparam int FLAG_TRAP_BIT = 27;
  localparam int PAIR_BYTES    = 8;

  typedef struct packed {
    logic imm;
    logic fin;
    logic dbg;
    logic trap;
  } pair_flags_t;

  function automatic pair_flags_t decode_flags(input logic [31:0] upper);
    pair_flags_t f;
    f.imm  = upper[FLAG_IMM_BIT];
    f.fin  = upper[FLAG_END_BIT];
    f.dbg  = upper[FLAG_DBG_BIT];
    f.trap = upper[FLAG_TRAP_BIT];
    return f;
  endfunction

endpackage

// File: rtl/vseq_branch_unit.sv
module vseq_branch_unit
  import vseq_pkg::*;
#(
  parameter int PC_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            issue_i,
  input  logic            arm_i,
  input  logic [PC_W-1:0] target_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] pc_next_o,
  output logic            pend_next_o,
  output logic            pend_o
);

  localparam logic [PC_W-1:0] STEP = PC_W'(PAIR_BYTES);

  logic            pend_q, pend_d;
  logic [PC_W-1:0] tgt_q, tgt_d;
  logic            en;

  // A pending target is applied after the current pair; a branch taken in the
  // same pair (the delay slot) replaces it and is applied one pair later.
  always_comb begin
    pend_d    = pend_q;
    tgt_d     = tgt_q;
    pc_next_o = pc_i + STEP;
    if (issue_i) begin
      if (pend_q) begin
        pc_next_o = tgt_q;
        pend_d    = 1'b0;
      end
      if (arm_i) begin
        pend_d = 1'b1;
        tgt_d  = target_i;
      end
    end
    if (clr_i) pend_d = 1'b0;
  end

  assign en          = clr_i | issue_i;
  assign pend_next_o = pend_d;
  assign pend_o      = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tgt_q  <= '0;
    end else if (en) begin
      pend_q <= pend_d;
      tgt_q  <= tgt_d;
    end
  end

  assert_arm_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && arm_i && !clr_i |=> pend_q);

  assert_pend_consumed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && pend_q && !arm_i |=> !pend_q);

endmodule

// File: rtl/vseq_stop_ctl.sv
module vseq_stop_ctl
  import vseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  pair_flags_t flags_i,
  input  logic        dbg_en_i,
  input  logic        trap_en_i,
  input  logic        br_pend_next_i,
  output logic        run_o,
  output logic        tail_o,
  output logic        start_ok_o,
  output logic        dbg_stat_o,
  output logic        trap_stat_o,
  output logic        irq_o
);

  logic run_q, run_d, tail_q, tail_d, epend_q, epend_d;
  logic dbg_q, dbg_d, trap_q, trap_d, irq_q, irq_d;
  logic hit_dbg, hit_trap, stop, start_ok, en;

  always_comb begin
    start_ok = start_i & ~run_q & ~tail_q;
    hit_dbg  = run_q & flags_i.dbg & dbg_en_i;
    hit_trap = run_q & flags_i.trap & trap_en_i;
    stop     = run_q & (epend_q | hit_dbg | hit_trap);

    run_d   = run_q;
    tail_d  = 1'b0;
    epend_d = epend_q;
    dbg_d   = dbg_q | hit_dbg;
    trap_d  = trap_q | hit_trap;
    irq_d   = hit_dbg | hit_trap;

    if (start_ok) begin
      run_d   = 1'b1;
      epend_d = 1'b0;
      dbg_d   = 1'b0;
      trap_d  = 1'b0;
    end else if (stop) begin
      run_d   = 1'b0;
      epend_d = 1'b0;
      tail_d  = br_pend_next_i;
    end else if (run_q && flags_i.fin) begin
      epend_d = 1'b1;
    end
  end

  assign en = start_ok | run_q | tail_q | irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      tail_q  <= 1'b0;
      epend_q <= 1'b0;
      dbg_q   <= 1'b0;
      trap_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else if (en) begin
      run_q   <= run_d;
      tail_q  <= tail_d;
      epend_q <= epend_d;
      dbg_q   <= dbg_d;
      trap_q  <= trap_d;
      irq_q   <= irq_d;
    end
  end

  assign run_o       = run_q;
  assign tail_o      = tail_q;
  assign start_ok_o  = start_ok;
  assign dbg_stat_o  = dbg_q;
  assign trap_stat_o = trap_q;
  assign irq_o       = irq_q;

  assert_run_tail_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && tail_q));

  assert_tail_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tail_q |=> !tail_q);

  assert_end_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && epend_q |=> !run_q);

  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (dbg_q || trap_q));

endmodule

// File: rtl/vseq_top.sv
module vseq_top
  import vseq_pkg::*;
#(
  parameter int PC_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [PC_W-1:0] start_pc_i,
  input  logic            dbg_en_i,
  input  logic            trap_en_i,
  input  logic [31:0]     upper_i,
  input  logic [31:0]     lower_i,
  input  logic            br_taken_i,
  input  logic [PC_W-1:0] br_target_i,
  output logic [PC_W-1:0] pc_o,
  output logic            issue_o,
  output logic            running_o,
  output logic            dbg_stat_o,
  output logic            trap_stat_o,
  output logic            irq_o,
  output logic [31:0]     imm_o
);

  localparam int ALIGN = $clog2(PAIR_BYTES);

  logic            rst_meta, rst_n_s;
  pair_flags_t     flags;
  logic            run, tail, issue, start_ok, pend, pend_next;
  logic [PC_W-1:0] pc_q, pc_d, pc_next;
  logic [31:0]     imm_q;
  logic            pc_en, imm_en;
  logic            unused_upper_bits;

  // Reset asserts at once and releases after two edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  assign flags             = decode_flags(upper_i);
  assign unused_upper_bits = ^{upper_i[29], upper_i[26:0]};
  assign issue             = run | tail;

  vseq_stop_ctl u_stop (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .start_i        (start_i),
    .flags_i        (flags),
    .dbg_en_i       (dbg_en_i),
    .trap_en_i      (trap_en_i),
    .br_pend_next_i (pend_next),
    .run_o          (run),
    .tail_o         (tail),
    .start_ok_o     (start_ok),
    .dbg_stat_o     (dbg_stat_o),
    .trap_stat_o    (trap_stat_o),
    .irq_o          (irq_o)
  );

  vseq_branch_unit #(.PC_W(PC_W)) u_branch (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .clr_i       (start_ok),
    .issue_i     (issue),
    .arm_i       (run & br_taken_i),
    .target_i    (br_target_i),
    .pc_i        (pc_q),
    .pc_next_o   (pc_next),
    .pend_next_o (pend_next),
    .pend_o      (pend)
  );

  always_comb begin
    pc_en  = start_ok | issue;
    imm_en = issue & flags.imm;
    pc_d   = start_ok ? {start_pc_i[PC_W-1:ALIGN], {ALIGN{1'b0}}} : pc_next;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pc_q  <= '0;
      imm_q <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (imm_en) imm_q <= lower_i;
    end
  end

  assign pc_o      = pc_q;
  assign imm_o     = imm_q;
  assign issue_o   = issue;
  assign running_o = run;

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    issue && !pend |=> pc_q == $past(pc_q) + PC_W'(PAIR_BYTES));

  assert_pc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !issue && !start_ok |=> $stable(pc_q));

  assert_start_align_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    start_ok |=> pc_q[ALIGN-1:0] == '0 && run);

  assert_imm_hold_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(issue && flags.imm) |=> $stable(imm_q));

endmodule

// File: tb/vseq_top_bench.sv
module vseq_top_bench;

  localparam int PC_W = 14;
  localparam int NV   = 26;

  typedef struct packed {
    logic [3:0]      req;
    logic            st;
    logic [PC_W-1:0] spc;
    logic [3:0]      fl;   // imm, end, dbg, trap
    logic [1:0]      en;   // dbg enable, trap enable
    logic            br;
    logic [PC_W-1:0] tgt;
    logic [PC_W-1:0] pc;
    logic            run;
    logic            iss;
    logic            irq;
    logic            dsb;
    logic            tsb;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{4'd2,  1'b1, 14'h0100, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h0100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 start
    '{4'd3,  1'b0, 14'h0000, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h0108, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd4,  1'b0, 14'h0000, 4'h0, 2'b00, 1'b1, 14'h0200, 14'h0110, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 branch
    '{4'd4,  1'b0, 14'h0000, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h0200, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 slot
    '{4'd3,  1'b0, 14'h0000, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h0208, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd5,  1'b0, 14'h0000, 4'h0, 2'b00, 1'b1, 14'h0300, 14'h0210, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R5
    '{4'd5,  1'b0, 14'h0000, 4'h0, 2'b00, 1'b1, 14'h0400, 14'h0300, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 chained
    '{4'd5,  1'b0, 14'h0000, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h0400, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R5
    '{4'd3,  1'b0, 14'h0000, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h0408, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd2,  1'b1, 14'h0040, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h0410, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 ignored
    '{4'd6,  1'b0, 14'h0000, 4'h4, 2'b00, 1'b0, 14'h0000, 14'h0418, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 end
    '{4'd6,  1'b0, 14'h0000, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h0420, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 trailing
    '{4'd6,  1'b0, 14'h0000, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h0420, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 idle
    '{4'd2,  1'b1, 14'h3FFD, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h3FF8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 align
    '{4'd3,  1'b0, 14'h0000, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 wrap
    '{4'd7,  1'b0, 14'h0000, 4'h2, 2'b10, 1'b0, 14'h0000, 14'h0008, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R7 break
    '{4'd11, 1'b0, 14'h0000, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h0008, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R11 sticky
    '{4'd11, 1'b1, 14'h0080, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h0080, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R11 clear
    '{4'd7,  1'b0, 14'h0000, 4'h2, 2'b00, 1'b0, 14'h0000, 14'h0088, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 disabled
    '{4'd8,  1'b0, 14'h0000, 4'h1, 2'b00, 1'b0, 14'h0000, 14'h0090, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 disabled
    '{4'd8,  1'b0, 14'h0000, 4'h1, 2'b01, 1'b1, 14'h0500, 14'h0098, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R8 trap
    '{4'd10, 1'b0, 14'h0000, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h0500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 tail
    '{4'd10, 1'b0, 14'h0000, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h0500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 idle
    '{4'd11, 1'b1, 14'h0600, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h0600, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R11
    '{4'd6,  1'b0, 14'h0000, 4'h4, 2'b00, 1'b1, 14'h0700, 14'h0608, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 end+branch
    '{4'd10, 1'b0, 14'h0000, 4'h0, 2'b00, 1'b0, 14'h0000, 14'h0700, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R10 no tail
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start_i;
  logic [PC_W-1:0] start_pc_i;
  logic            dbg_en_i, trap_en_i;
  logic [31:0]     upper_i, lower_i;
  logic            br_taken_i;
  logic [PC_W-1:0] br_target_i;
  logic [PC_W-1:0] pc_o;
  logic            issue_o, running_o, dbg_stat_o, trap_stat_o, irq_o;
  logic [31:0]     imm_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  vseq_top #(.PC_W(PC_W)) u_vseq_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_pc_i  (start_pc_i),
    .dbg_en_i    (dbg_en_i),
    .trap_en_i   (trap_en_i),
    .upper_i     (upper_i),
    .lower_i     (lower_i),
    .br_taken_i  (br_taken_i),
    .br_target_i (br_target_i),
    .pc_o        (pc_o),
    .issue_o     (issue_o),
    .running_o   (running_o),
    .dbg_stat_o  (dbg_stat_o),
    .trap_stat_o (trap_stat_o),
    .irq_o       (irq_o),
    .imm_o       (imm_o)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    start_i     = 1'b0;
    start_pc_i  = '0;
    dbg_en_i    = 1'b0;
    trap_en_i   = 1'b0;
    upper_i     = '0;
    lower_i     = '0;
    br_taken_i  = 1'b0;
    br_target_i = '0;
  endtask

  function automatic logic [PC_W+4:0] outs();
    return {pc_o, running_o, issue_o, irq_o, dbg_stat_o, trap_stat_o};
  endfunction

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1", "reset outs", 64'(outs()), 64'(0));
    check("R1", "reset imm", 64'(imm_o), 64'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "after release", 64'(outs()), 64'(0));

    for (int i = 0; i < NV; i++) begin
      start_i     = VEC[i].st;
      start_pc_i  = VEC[i].spc;
      upper_i     = {VEC[i].fl[3], VEC[i].fl[2], 1'b0, VEC[i].fl[1], VEC[i].fl[0], 27'b0};
      lower_i     = '0;
      dbg_en_i    = VEC[i].en[1];
      trap_en_i   = VEC[i].en[0];
      br_taken_i  = VEC[i].br;
      br_target_i = VEC[i].tgt;
      @(negedge clk);
      n_chk++;
      if (outs() !== {VEC[i].pc, VEC[i].run, VEC[i].iss, VEC[i].irq, VEC[i].dsb, VEC[i].tsb}) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: actual pc=%0h run=%b iss=%b irq=%b d=%b t=%b expected pc=%0h run=%b iss=%b irq=%b d=%b t=%b",
                 VEC[i].req, i, pc_o, running_o, issue_o, irq_o, dbg_stat_o, trap_stat_o,
                 VEC[i].pc, VEC[i].run, VEC[i].iss, VEC[i].irq, VEC[i].dsb, VEC[i].tsb);
      end
    end

    // R9: immediate capture and hold
    idle_inputs();
    upper_i = 32'h8000_0000;
    lower_i = 32'h0000_0055;
    @(negedge clk);
    check("R9", "imm while idle", 64'(imm_o), 64'(0));
    idle_inputs();
    start_i    = 1'b1;
    start_pc_i = 14'h0020;
    @(negedge clk);
    check("R2", "restart pc", 64'(pc_o), 64'h20);
    idle_inputs();
    upper_i = 32'h8000_0000;
    lower_i = 32'hDEAD_BEEF;
    @(negedge clk);
    check("R9", "imm load", 64'(imm_o), 64'hDEAD_BEEF);
    upper_i = 32'h0000_0000;
    lower_i = 32'h1234_5678;
    @(negedge clk);
    check("R9", "imm hold", 64'(imm_o), 64'hDEAD_BEEF);
    check("R3", "pc after imm pairs", 64'(pc_o), 64'h30);

    // R1: reset in mid-run acts at once
    rst_n = 1'b0;
    #1;
    check("R1", "mid-run reset outs", 64'(outs()), 64'(0));
    check("R1", "mid-run reset imm", 64'(imm_o), 64'(0));
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule